// File: doc/BRIEF.md
# Interrupt-Sensing GPIO Bank

A bank of 32 general-purpose pins behind a simple single-cycle register bus. Software sets each pin's direction, drives output values through a data latch, and reads back the live pin state. Every pin also carries an interrupt detector. The detector watches the pin after a two-flop synchronizer and flags one trigger condition. The condition is a rising edge, a falling edge, either edge, a high level or a low level, and three per-pin type bits choose it.

Enabled events are held in a status register until software clears them by writing ones. The OR of all status bits drives a single registered interrupt line, which goes to the system interrupt controller. A bus access takes effect on the clock edge where `busSel` is high. Read data is combinational from the addressed register.

Top module: `gpio_sense_bank`

## Requirements
- R1: After reset every register reads zero, `pinOe` is all zero (all pins are inputs), and `irqOut` is low.
- R2: Byte offsets are: data 0x00, direction 0x04, interrupt enable 0x08, type0 0x0C, type1 0x10, type2 0x14, status 0x18. The enable and type registers read back what was written. A read of any other offset returns zero, and a write to any other offset changes no register.
- R3: A direction bit of 1 makes the pin an output, so its `pinOe` bit is 1. A direction bit of 0 makes the pin an input. `pinOut` always presents the data latch.
- R4: A data read returns the data latch on output pins and the synchronized `pinIn` value on input pins. A data write changes only the latch.
- R5: With type1=0, type2=0 and type0=0, an enabled pin sets its status bit on a falling edge only.
- R6: With type1=0, type2=0 and type0=1, an enabled pin sets its status bit on a rising edge only.
- R7: With type1=0 and type2=1, both edges set the status bit, whatever the value of type0.
- R8: With type1=1, the pin is level-sensed: type0=1 means active high and type0=0 means active low. While the level persists, the status bit is set again one cycle after a clear.
- R9: A pin whose enable bit is 0 never sets its status bit.
- R10: Writing status clears every bit written as 1 and leaves every bit written as 0. A clear takes priority over an event in the same cycle.
- R11: `irqOut` is a register holding the OR of the status bits. It rises one cycle after a status bit sets and falls one cycle after the last bit clears.
- R12: Suppose `pinIn` changes before clock edge k. A qualifying edge event is then visible in status after edge k+2 and not before, and `irqOut` rises after edge k+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data (combinational) |
| pinIn | input | 32 | Asynchronous pin inputs |
| pinOut | output | 32 | Output data latch |
| pinOe | output | 32 | Output enable per pin |
| irqOut | output | 1 | Bank interrupt request |

## Verification
The bench drives each trigger mode on its own pin. It gives each pin a rise followed by a fall, so the test tells edges of the right polarity from those of the wrong one. Dual-edge mode is tried with type0 at 0 to show that polarity is ignored. Level mode is held across a status clear to show the bit is set again. The active-low level starts already true, which separates level sensing from edge sensing. A disabled pin given a valid edge must leave status untouched. Two pins set together, then cleared one at a time, show that zero bits in a clear write do no harm.

// File: rtl/gsb_pkg.sv
package gsb_pkg;
  localparam logic [7:0] OFS_DATA = 8'h00;
  localparam logic [7:0] OFS_DIR  = 8'h04;
  localparam logic [7:0] OFS_EN   = 8'h08;
  localparam logic [7:0] OFS_T0   = 8'h0C;
  localparam logic [7:0] OFS_T1   = 8'h10;
  localparam logic [7:0] OFS_T2   = 8'h14;
  localparam logic [7:0] OFS_STAT = 8'h18;

  typedef enum logic [2:0] {
    RD_NONE, RD_DATA, RD_DIR, RD_EN, RD_T0, RD_T1, RD_T2, RD_STAT
  } rdSel_t;

  typedef struct packed {
    logic   wrData;
    logic   wrDir;
    logic   wrEn;
    logic   wrT0;
    logic   wrT1;
    logic   wrT2;
    logic   wrClr;
    rdSel_t rdSel;
  } strobe_t;
endpackage

// File: rtl/gsb_ctrl.sv
module gsb_ctrl
  import gsb_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           strb
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(OFS_DIR);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFS_EN);
  localparam logic [ADDR_W-1:0] A_T0   = ADDR_W'(OFS_T0);
  localparam logic [ADDR_W-1:0] A_T1   = ADDR_W'(OFS_T1);
  localparam logic [ADDR_W-1:0] A_T2   = ADDR_W'(OFS_T2);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

  logic isWr;
  logic isRd;
  assign isWr = busSel & busWr;
  assign isRd = busSel & ~busWr;

  always_comb begin
    strb       = '0;
    strb.rdSel = RD_NONE;
    unique case (busAddr)
      A_DATA: begin strb.wrData = isWr; if (isRd) strb.rdSel = RD_DATA; end
      A_DIR:  begin strb.wrDir  = isWr; if (isRd) strb.rdSel = RD_DIR;  end
      A_EN:   begin strb.wrEn   = isWr; if (isRd) strb.rdSel = RD_EN;   end
      A_T0:   begin strb.wrT0   = isWr; if (isRd) strb.rdSel = RD_T0;   end
      A_T1:   begin strb.wrT1   = isWr; if (isRd) strb.rdSel = RD_T1;   end
      A_T2:   begin strb.wrT2   = isWr; if (isRd) strb.rdSel = RD_T2;   end
      A_STAT: begin strb.wrClr  = isWr; if (isRd) strb.rdSel = RD_STAT; end
      default: ;
    endcase
  end

  // R2
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrData, strb.wrDir, strb.wrEn, strb.wrT0,
              strb.wrT1, strb.wrT2, strb.wrClr}));

  // R2
  no_write_on_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr) |-> ({strb.wrData, strb.wrDir, strb.wrEn, strb.wrT0,
                             strb.wrT1, strb.wrT2, strb.wrClr} == 7'd0));
endmodule

// File: rtl/gsb_pin_sense.sv
module gsb_pin_sense (
  input  logic clk,
  input  logic rstN,
  input  logic pinRaw,
  input  logic selPol,
  input  logic selLevel,
  input  logic selBoth,
  output logic pinSync,
  output logic hit
);
  logic stage1Q;
  logic stage2Q;
  logic prevQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage1Q <= 1'b0;
      stage2Q <= 1'b0;
      prevQ   <= 1'b0;
    end else begin
      stage1Q <= pinRaw;
      stage2Q <= stage1Q;
      prevQ   <= stage2Q;
    end
  end

  logic rise;
  logic fall;
  logic levelHit;
  logic edgeHit;

  assign rise     = stage2Q & ~prevQ;
  assign fall     = ~stage2Q & prevQ;
  assign levelHit = selPol ? stage2Q : ~stage2Q;
  assign edgeHit  = selBoth ? (rise | fall) : (selPol ? rise : fall);
  assign hit      = selLevel ? levelHit : edgeHit;
  assign pinSync  = stage2Q;
endmodule

// File: rtl/gsb_datapath.sv
module gsb_datapath
  import gsb_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [NPINS-1:0] busWdata,
  output logic [NPINS-1:0] busRdata,
  input  logic [NPINS-1:0] pinIn,
  output logic [NPINS-1:0] pinOut,
  output logic [NPINS-1:0] pinOe,
  output logic             irqOut
);
  logic [NPINS-1:0] dataQ, dirQ, enQ, t0Q, t1Q, t2Q, statQ;
  logic             irqQ;
  logic [NPINS-1:0] syncVec;
  logic [NPINS-1:0] hitVec;
  logic [NPINS-1:0] clrMask;
  logic [NPINS-1:0] statNext;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    gsb_pin_sense u_sense (
      .clk      (clk),
      .rstN     (rstN),
      .pinRaw   (pinIn[p]),
      .selPol   (t0Q[p]),
      .selLevel (t1Q[p]),
      .selBoth  (t2Q[p]),
      .pinSync  (syncVec[p]),
      .hit      (hitVec[p])
    );
  end

  assign clrMask  = strb.wrClr ? busWdata : '0;
  assign statNext = (statQ | (hitVec & enQ)) & ~clrMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataQ <= '0;
      dirQ  <= '0;
      enQ   <= '0;
      t0Q   <= '0;
      t1Q   <= '0;
      t2Q   <= '0;
      statQ <= '0;
      irqQ  <= 1'b0;
    end else begin
      if (strb.wrData) dataQ <= busWdata;
      if (strb.wrDir)  dirQ  <= busWdata;
      if (strb.wrEn)   enQ   <= busWdata;
      if (strb.wrT0)   t0Q   <= busWdata;
      if (strb.wrT1)   t1Q   <= busWdata;
      if (strb.wrT2)   t2Q   <= busWdata;
      statQ <= statNext;
      irqQ  <= |statQ;
    end
  end

  always_comb begin
    unique case (strb.rdSel)
      RD_DATA: busRdata = (dataQ & dirQ) | (syncVec & ~dirQ);
      RD_DIR:  busRdata = dirQ;
      RD_EN:   busRdata = enQ;
      RD_T0:   busRdata = t0Q;
      RD_T1:   busRdata = t1Q;
      RD_T2:   busRdata = t2Q;
      RD_STAT: busRdata = statQ;
      default: busRdata = '0;
    endcase
  end

  assign pinOut = dataQ;
  assign pinOe  = dirQ;
  assign irqOut = irqQ;

  // R3
  dir_drives_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrDir |=> (pinOe == $past(busWdata)));

  // R9
  enabled_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statQ & ~$past(statQ) & ~$past(enQ)) == '0));

  // R10
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrClr |=> ((statQ & $past(busWdata)) == '0));

  // R10
  w1c_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrClr |=> ((~statQ & $past(statQ) & ~$past(busWdata)) == '0));

  // R11
  irq_falls_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statQ == '0) |=> !irqOut);

  // R11
  irq_rises_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statQ != '0) |=> irqOut);
endmodule

// File: rtl/gpio_sense_bank.sv
module gpio_sense_bank
  import gsb_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [NPINS-1:0]  busWdata,
  output logic [NPINS-1:0]  busRdata,
  input  logic [NPINS-1:0]  pinIn,
  output logic [NPINS-1:0]  pinOut,
  output logic [NPINS-1:0]  pinOe,
  output logic              irqOut
);
  strobe_t strb;

  gsb_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busSel  (busSel),
    .busWr   (busWr),
    .busAddr (busAddr),
    .strb    (strb)
  );

  gsb_datapath #(.NPINS(NPINS)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .pinIn    (pinIn),
    .pinOut   (pinOut),
    .pinOe    (pinOe),
    .irqOut   (irqOut)
  );
endmodule

// File: tb/gpio_sense_bank_tb.sv
`timescale 1ns/100ps
module gpio_sense_bank_tb_top;
  localparam logic [7:0] A_DATA = 8'h00, A_DIR = 8'h04, A_EN = 8'h08,
                         A_T0 = 8'h0C, A_T1 = 8'h10, A_T2 = 8'h14, A_STAT = 8'h18;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] pinIn = '0;
  logic [31:0] pinOut;
  logic [31:0] pinOe;
  logic        irqOut;

  int nChecks = 0;
  int nFail = 0;

  always #2 clk = ~clk;

  gpio_sense_bank dut_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .pinIn(pinIn), .pinOut(pinOut),
    .pinOe(pinOe), .irqOut(irqOut)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; busWdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1;
    d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic cfg(input logic [31:0] en, input logic [31:0] t0,
                     input logic [31:0] t1, input logic [31:0] t2);
    wr(A_EN, 32'h0);
    wr(A_T0, t0);
    wr(A_T1, t1);
    wr(A_T2, t2);
    step(3);
    wr(A_STAT, 32'hFFFF_FFFF);
    wr(A_EN, en);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rstN = 1'b0;
    step(3);
    rstN = 1'b1;
    step(1);
    for (int i = 0; i < 7; i++) begin
      rd(8'(i * 4), v);
      chk($sformatf("R1 reg %0d after reset", i), v, 32'h0);
    end
    chk("R1 pinOe after reset", pinOe, 32'h0);
    chk("R1 irqOut after reset", {31'h0, irqOut}, 32'h0);
  endtask

  task automatic t_map();
    logic [31:0] v;
    wr(A_T0, 32'h1111_0000);
    wr(A_T1, 32'h2222_0000);
    wr(A_T2, 32'h4444_0000);
    rd(A_T0, v); chk("R2 type0 readback", v, 32'h1111_0000);
    rd(A_T1, v); chk("R2 type1 readback", v, 32'h2222_0000);
    rd(A_T2, v); chk("R2 type2 readback", v, 32'h4444_0000);
    wr(A_EN, 32'h0);
    rd(A_EN, v); chk("R2 enable readback", v, 32'h0);
    wr(8'h1C, 32'hFFFF_FFFF);
    wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h1C, v); chk("R2 unmapped read", v, 32'h0);
    rd(A_DIR, v); chk("R2 unmapped write leaves dir", v, 32'h0);
    rd(A_T0, v);  chk("R2 unmapped write leaves type0", v, 32'h1111_0000);
    wr(A_T0, 32'h0); wr(A_T1, 32'h0); wr(A_T2, 32'h0);
  endtask

  task automatic t_dir_data();
    logic [31:0] v;
    wr(A_DIR, 32'h0000_FFFF);
    wr(A_DATA, 32'hA5A5_5A5A);
    chk("R3 pinOe follows direction", pinOe, 32'h0000_FFFF);
    chk("R3 pinOut shows latch", pinOut, 32'hA5A5_5A5A);
    pinIn = 32'h1234_C3C3;
    step(3);
    rd(A_DATA, v); chk("R4 mixed data read", v, 32'h1234_5A5A);
    wr(A_DATA, 32'h0);
    rd(A_DATA, v); chk("R4 write keeps input bits", v, 32'h1234_0000);
    pinIn = 32'h0;
    wr(A_DIR, 32'h0);
    step(3);
    rd(A_DATA, v); chk("R4 all inputs low", v, 32'h0);
  endtask

  task automatic t_falling();
    logic [31:0] v;
    cfg(32'h1, 32'h0, 32'h0, 32'h0);
    pinIn[0] = 1'b1; step(4);
    rd(A_STAT, v); chk("R5 rise ignored in falling mode", v, 32'h0);
    pinIn[0] = 1'b0; step(4);
    rd(A_STAT, v); chk("R5 falling edge sets", v, 32'h1);
    wr(A_STAT, 32'h1);
  endtask

  task automatic t_rising();
    logic [31:0] v;
    cfg(32'h2, 32'h2, 32'h0, 32'h0);
    pinIn[1] = 1'b1; step(4);
    rd(A_STAT, v); chk("R6 rising edge sets", v, 32'h2);
    wr(A_STAT, 32'h2);
    pinIn[1] = 1'b0; step(4);
    rd(A_STAT, v); chk("R6 fall ignored in rising mode", v, 32'h0);
  endtask

  task automatic t_both();
    logic [31:0] v;
    cfg(32'h4, 32'h0, 32'h0, 32'h4);
    pinIn[2] = 1'b1; step(4);
    rd(A_STAT, v); chk("R7 dual mode rise", v, 32'h4);
    wr(A_STAT, 32'h4);
    pinIn[2] = 1'b0; step(4);
    rd(A_STAT, v); chk("R7 dual mode fall", v, 32'h4);
    wr(A_STAT, 32'h4);
  endtask

  task automatic t_level();
    logic [31:0] v;
    cfg(32'h8, 32'h8, 32'h8, 32'h8);
    pinIn[3] = 1'b1; step(4);
    rd(A_STAT, v); chk("R8 high level sets", v, 32'h8);
    wr(A_STAT, 32'h8);
    rd(A_STAT, v); chk("R10 clear wins over level", v, 32'h0);
    step(1);
    rd(A_STAT, v); chk("R8 level re-sets next cycle", v, 32'h8);
    pinIn[3] = 1'b0; step(3);
    wr(A_STAT, 32'h8); step(2);
    rd(A_STAT, v); chk("R8 gone level stays clear", v, 32'h0);
    cfg(32'h10, 32'h0, 32'h10, 32'h0);
    step(3);
    rd(A_STAT, v); chk("R8 active-low level sets", v, 32'h10);
    pinIn[4] = 1'b1; step(3);
    wr(A_STAT, 32'h10); step(2);
    rd(A_STAT, v); chk("R8 active-low released", v, 32'h0);
    pinIn[4] = 1'b0;
    wr(A_EN, 32'h0);
  endtask

  task automatic t_enable();
    logic [31:0] v;
    cfg(32'h0, 32'h20, 32'h0, 32'h0);
    pinIn[5] = 1'b1; step(5);
    rd(A_STAT, v); chk("R9 disabled pin no status", v, 32'h0);
    chk("R9 disabled pin no irq", {31'h0, irqOut}, 32'h0);
    pinIn[5] = 1'b0; step(3);
    wr(A_EN, 32'h20);
    pinIn[5] = 1'b1; step(4);
    rd(A_STAT, v); chk("R9 enabled pin sets", v, 32'h20);
    wr(A_STAT, 32'h20);
  endtask

  task automatic t_w1c_irq();
    logic [31:0] v;
    cfg(32'hC0, 32'h0, 32'h0, 32'hC0);
    pinIn[7:6] = 2'b11; step(4);
    rd(A_STAT, v); chk("R10 two bits set", v, 32'hC0);
    chk("R11 irq high", {31'h0, irqOut}, 32'h1);
    wr(A_STAT, 32'h40);
    rd(A_STAT, v); chk("R10 clear one bit", v, 32'h80);
    wr(A_STAT, 32'h0);
    rd(A_STAT, v); chk("R10 zero write keeps", v, 32'h80);
    wr(A_STAT, 32'h80);
    rd(A_STAT, v); chk("R10 last bit cleared", v, 32'h0);
    chk("R11 irq still high one cycle", {31'h0, irqOut}, 32'h1);
    step(1);
    chk("R11 irq falls", {31'h0, irqOut}, 32'h0);
    pinIn[7:6] = 2'b00; step(4);
    wr(A_STAT, 32'hFFFF_FFFF);
    wr(A_EN, 32'h0);
  endtask

  task automatic t_latency();
    logic [31:0] v;
    cfg(32'h100, 32'h100, 32'h0, 32'h0);
    step(1);
    pinIn[8] = 1'b1;
    step(2);
    rd(A_STAT, v); chk("R12 not after edge k+1", v, 32'h0);
    step(1);
    rd(A_STAT, v); chk("R12 set after edge k+2", v, 32'h100);
    chk("R12 irq low after edge k+2", {31'h0, irqOut}, 32'h0);
    step(1);
    chk("R12 irq high after edge k+3", {31'h0, irqOut}, 32'h1);
    wr(A_STAT, 32'h100);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    t_reset();
    t_map();
    t_dir_data();
    t_falling();
    t_rising();
    t_both();
    t_level();
    t_enable();
    t_w1c_irq();
    t_latency();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule